// File: doc/BRIEF.md
# Descriptor-Driven Serial Word Scheduler

This block decides which 32-bit words go out on one serial transmit channel, and in what order. A local table of up to 256 eight-byte descriptors describes the words. Each descriptor holds four opcode/operand pairs, one for each byte of the output word. Each pair places either a fixed byte or a byte fetched from a receive-data memory into its byte of the word. The finished word is offered to a line transmitter over a valid/ready handshake.

The host loads the table through a simple write port, sets the mode inputs and raises `run`. The scheduler walks the table from entry 0 and builds and sends one word per entry. A pass ends at an end marker or after the last entry. The next pass then starts right away, or after a repetition-rate delay, or not at all, depending on the mode inputs. Words whose fresh-data condition fails are dropped silently. The receive entries used by a word that is actually sent have their fresh flags cleared.

Top module: `txseq_engine`

## Requirements
- R1: While reset is held and after its release, with `run` low, `tx_valid`, `rx_re` and `rx_clr` stay low.
- R2: Rising `run` from idle starts at entry 0. Entries are visited in ascending order, and after entry 255 the next entry is 0.
- R3: Descriptor bits [16k+7:16k] hold the opcode for word byte k, and bits [16k+15:16k+8] hold its operand (k = 0..3). Word byte k occupies `tx_word[8k+7:8k]`. Opcode 0x00, and any code other than 0x01, 0x02 or 0xFF-in-byte-0, places the operand itself. Opcodes 0x01 and 0x02 place the receive byte at address = operand.
- R4: If any byte of an entry uses opcode 0x02 and the fresh flag of its receive address is clear, the entry sends no word and the scheduler moves to the next entry.
- R5: After a word is accepted, one `rx_clr` pulse is issued for each byte that used opcode 0x01 or 0x02, with `rx_clr_addr` = that byte's operand. A skipped entry clears nothing.
- R6: An entry whose byte-0 opcode is 0xFF ends the pass without sending, and the next pass starts at entry 0.
- R7: With `rep_now` low, `one_pass` low and `rate_value` nonzero, the next pass begins at least `rate_value`×PRESCALE cycles after the previous pass ends.
- R8: With `rep_now` high or `rate_value` zero, the next pass starts without that delay.
- R9: With `one_pass` high, the scheduler runs one pass and then sends nothing more until `run` falls and rises again.
- R10: When `run` falls, a word already offered stays offered until it is accepted. No further word follows, and the next rising `run` restarts at entry 0.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_word` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Start/stop of the sequence |
| rep_now | input | 1 | Start the next pass at once, without the rate delay |
| one_pass | input | 1 | Stop after one pass |
| rate_value | input | RATE_W | Pass-to-pass delay in prescaled ticks |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_waddr | input | SLOT_W | Descriptor entry to write |
| tbl_wdata | input | 64 | Descriptor contents |
| rx_re | output | 1 | Receive memory read request |
| rx_raddr | output | 8 | Receive memory read address |
| rx_rdata | input | 8 | Receive byte, one cycle after `rx_re` |
| rx_fresh | input | 1 | Fresh flag of the read entry, one cycle after `rx_re` |
| rx_clr | output | 1 | Clear the fresh flag at `rx_clr_addr` |
| rx_clr_addr | output | 8 | Receive entry whose flag is cleared |
| tx_valid | output | 1 | Word offered to the transmitter |
| tx_word | output | 32 | Offered word |
| tx_ready | input | 1 | Transmitter accepts the word |

## Verification
The hardest case to reach is the interaction between flag clearing and skipping. A word must be dropped only because an earlier accepted word consumed the fresh flag it depends on. A skipped word must leave the flags of its other indexed bytes untouched. The stimulus reaches this with directed single-pass runs that set one flag, run the same table twice, and then inspect the receive-side flags. A long random run over a full 256-entry table, with mixed opcodes and a stalling transmitter, then lets a bench model track flag consumption across many table wraps.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_ISSUE, ST_TAKE, ST_SEND, ST_CLEAR, ST_WAIT, ST_HALT
  } seq_state_e;

  localparam logic [7:0] OP_IMM     = 8'h00;
  localparam logic [7:0] OP_IDX     = 8'h01;
  localparam logic [7:0] OP_IDX_NEW = 8'h02;
  localparam logic [7:0] OP_END     = 8'hFF;

  function automatic logic op_indexed(input logic [7:0] op);
    return (op == OP_IDX) || (op == OP_IDX_NEW);
  endfunction
endpackage

// File: rtl/txseq_rstsync.sv
module txseq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/txseq_table.sv
module txseq_table #(
  parameter int SLOT_W = 8,
  parameter int DESC_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DESC_W-1:0] wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DESC_W-1:0] rdata
);
  localparam int DEPTH = 1 << SLOT_W;

  logic [DESC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txseq_rate.sv
module txseq_rate #(
  parameter int RATE_W   = 16,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] reload,
  output logic              done
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0]  pre_q, pre_d;

  always_comb begin
    cnt_d = cnt_q;
    pre_d = pre_q;
    if (load) begin
      cnt_d = reload;
      pre_d = '0;
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        cnt_d = cnt_q - RATE_W'(1);
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/txseq_engine.sv
module txseq_engine
  import txseq_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int RATE_W   = 16,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rep_now,
  input  logic              one_pass,
  input  logic [RATE_W-1:0] rate_value,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_waddr,
  input  logic [63:0]       tbl_wdata,
  output logic              rx_re,
  output logic [7:0]        rx_raddr,
  input  logic [7:0]        rx_rdata,
  input  logic              rx_fresh,
  output logic              rx_clr,
  output logic [7:0]        rx_clr_addr,
  output logic              tx_valid,
  output logic [31:0]       tx_word,
  input  logic              tx_ready
);
  localparam int DESC_W = 64;
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic              rst_sync_n;
  logic [DESC_W-1:0] tbl_rd;
  logic              rate_load, rate_done;

  seq_state_e        st_q, st_d;
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [1:0]        lane_q, lane_d;
  logic [DESC_W-1:0] desc_q, desc_d;
  logic [31:0]       word_q, word_d;
  logic              skip_q, skip_d;
  logic [3:0]        used_q, used_d;
  logic              desc_en, step, pass_end;
  logic [7:0]        act_cur, val_cur, lane_byte;

  txseq_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  txseq_table #(.SLOT_W(SLOT_W), .DESC_W(DESC_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(ptr_q), .rdata(tbl_rd)
  );

  txseq_rate #(.RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_rate (
    .clk(clk), .rst_n(rst_sync_n), .load(rate_load), .reload(rate_value),
    .done(rate_done)
  );

  assign act_cur   = desc_q[{lane_q, 4'b0000} +: 8];
  assign val_cur   = desc_q[{lane_q, 4'b1000} +: 8];
  assign lane_byte = op_indexed(act_cur) ? rx_rdata : val_cur;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    lane_d    = lane_q;
    desc_d    = desc_q;
    word_d    = word_q;
    skip_d    = skip_q;
    used_d    = used_q;
    desc_en   = 1'b0;
    rate_load = 1'b0;
    step      = 1'b0;
    pass_end  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ptr_d = '0;
        if (run) st_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (!run) begin
          st_d = ST_IDLE; ptr_d = '0;
        end else if (tbl_rd[7:0] == OP_END) begin
          pass_end = 1'b1;
        end else begin
          desc_en = 1'b1; desc_d = tbl_rd;
          lane_d = '0; skip_d = 1'b0; used_d = '0;
          st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!run) begin st_d = ST_IDLE; ptr_d = '0; end
        else st_d = ST_TAKE;
      end
      ST_TAKE: begin
        if (!run) begin
          st_d = ST_IDLE; ptr_d = '0;
        end else begin
          word_d[{lane_q, 3'b000} +: 8] = lane_byte;
          if (act_cur == OP_IDX_NEW && !rx_fresh) skip_d = 1'b1;
          used_d[lane_q] = op_indexed(act_cur);
          if (lane_q == 2'd3) begin
            if (skip_d) step = 1'b1;
            else        st_d = ST_SEND;
          end else begin
            lane_d = lane_q + 2'd1;
            st_d   = ST_ISSUE;
          end
        end
      end
      ST_SEND: begin
        if (tx_ready) begin st_d = ST_CLEAR; lane_d = '0; end
      end
      ST_CLEAR: begin
        lane_d = lane_q + 2'd1;
        if (lane_q == 2'd3) begin
          if (run) step = 1'b1;
          else begin st_d = ST_IDLE; ptr_d = '0; end
        end
      end
      ST_WAIT: begin
        if (!run) begin st_d = ST_IDLE; ptr_d = '0; end
        else if (rate_done) st_d = ST_LOAD;
      end
      ST_HALT: begin
        if (!run) begin st_d = ST_IDLE; ptr_d = '0; end
      end
      default: st_d = ST_IDLE;
    endcase

    if (step) begin
      if (ptr_q == LAST_SLOT) pass_end = 1'b1;
      else begin
        ptr_d = ptr_q + SLOT_W'(1);
        st_d  = ST_LOAD;
      end
    end

    if (pass_end) begin
      ptr_d = '0;
      if (one_pass)                         st_d = ST_HALT;
      else if (rep_now || rate_value == '0) st_d = ST_LOAD;
      else begin
        st_d      = ST_WAIT;
        rate_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      lane_q <= '0;
      word_q <= '0;
      skip_q <= 1'b0;
      used_q <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      lane_q <= lane_d;
      word_q <= word_d;
      skip_q <= skip_d;
      used_q <= used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (desc_en) desc_q <= desc_d;
  end

  assign rx_re       = (st_q == ST_ISSUE) && op_indexed(act_cur);
  assign rx_raddr    = val_cur;
  assign rx_clr      = (st_q == ST_CLEAR) && used_q[lane_q];
  assign rx_clr_addr = val_cur;
  assign tx_valid    = (st_q == ST_SEND);
  assign tx_word     = word_q;
endmodule

// File: rtl/txseq_engine_chk.sv
module txseq_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_word,
  input logic        rx_re,
  input logic        rx_clr
);
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_word)); // R11

  AST_CLEAR_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> !tx_valid && !rx_re); // R5

  AST_STOP_NO_NEW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !tx_valid |=> !tx_valid); // R10

  AST_STOP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rx_re); // R10

  AST_READ_NOT_OFFERING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_re |-> !tx_valid); // R3

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!tx_valid && !rx_re && !rx_clr); // R1
    end
  end
endmodule

bind txseq_engine txseq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_word(tx_word), .rx_re(rx_re), .rx_clr(rx_clr)
);

// File: tb/sim_txseq_engine.sv
`timescale 1ns/1ps
module sim_txseq_engine;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, rep_now, one_pass;
  logic [15:0] rate_value;
  logic        tbl_we;
  logic [7:0]  tbl_waddr;
  logic [63:0] tbl_wdata;
  logic        rx_re, rx_clr, tx_valid, tx_ready;
  logic [7:0]  rx_raddr, rx_rdata, rx_clr_addr;
  logic        rx_fresh;
  logic [31:0] tx_word;

  bit [63:0] tbl_m [256];
  bit [7:0]  rxm [256];
  bit        rxf [256];
  bit        shf [256];

  int    errs = 0, checks = 0, got = 0, cur = 0, cyc = 0;
  int    last_hs = 0, prev_hs = 0, ready_mode = 1;
  bit    pulse_req = 0;
  bit [31:0] last_word;
  string cur_req = "R2";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  txseq_engine #(.SLOT_W(8), .RATE_W(16), .PRESCALE(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .rep_now(rep_now), .one_pass(one_pass),
    .rate_value(rate_value), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .rx_re(rx_re), .rx_raddr(rx_raddr),
    .rx_rdata(rx_rdata), .rx_fresh(rx_fresh), .rx_clr(rx_clr),
    .rx_clr_addr(rx_clr_addr), .tx_valid(tx_valid), .tx_word(tx_word),
    .tx_ready(tx_ready)
  );

  // receive memory model: one-cycle read latency, flag clear port
  always @(posedge clk) begin
    if (rx_re) begin
      rx_rdata <= rxm[rx_raddr];
      rx_fresh <= rxf[rx_raddr];
    end
    if (rx_clr) rxf[rx_clr_addr] <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model: next word to be sent, per the requirements
  task automatic next_exp(output bit [31:0] w, output bit ok);
    bit [63:0] d;
    bit [7:0]  op, v;
    bit        skip;
    ok = 0;
    w  = '0;
    for (int guard = 0; guard < 600 && !ok; guard++) begin
      d = tbl_m[cur];
      if (d[7:0] == 8'hFF) begin cur = 0; continue; end
      skip = 0;
      for (int k = 0; k < 4; k++) begin
        op = d[16*k +: 8];
        v  = d[16*k+8 +: 8];
        w[8*k +: 8] = (op == 8'h01 || op == 8'h02) ? rxm[v] : v;
        if (op == 8'h02 && !shf[v]) skip = 1;
      end
      if (!skip) begin
        for (int k = 0; k < 4; k++) begin
          op = d[16*k +: 8];
          if (op == 8'h01 || op == 8'h02) shf[d[16*k+8 +: 8]] = 0;
        end
        ok = 1;
      end
      cur = (cur == 255) ? 0 : cur + 1;
    end
  endtask

  always @(negedge clk) begin
    bit [31:0] ew;
    bit        ok;
    if (!rst_n) tx_ready = 1'b0;
    else begin
      case (ready_mode)
        0:       tx_ready = ($urandom % 10) < 7;
        1:       tx_ready = 1'b1;
        default: begin tx_ready = pulse_req; pulse_req = 0; end
      endcase
      if (tx_valid && tx_ready) begin
        next_exp(ew, ok);
        got++;
        prev_hs   = last_hs;
        last_hs   = cyc;
        last_word = tx_word;
        chk(ok && tx_word == ew, cur_req, tx_word, ew);
      end
    end
  end

  function automatic bit [63:0] mk(bit [7:0] a0, v0, a1, v1, a2, v2, a3, v3);
    return {v3, a3, v2, a2, v1, a1, v0, a0};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int s, bit [63:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = s[7:0]; tbl_wdata = d; tbl_m[s] = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic set_flag(int a, bit v);
    rxf[a] = v; shf[a] = v;
  endtask

  task automatic start(bit single);
    @(negedge clk);
    cur = 0; one_pass = single; run = 1;
  endtask

  task automatic stop();
    @(negedge clk);
    run = 0;
    tick(30);
  endtask

  task automatic wait_got(int n, int lim, string tag);
    int t = 0;
    while (got < n && t < lim) begin @(negedge clk); t++; end
    chk(got >= n, tag, got, n);
  endtask

  initial begin
    int base, gap;
    bit [7:0] op;
    void'($urandom(32'd2024));
    rst_n = 0; run = 0; rep_now = 0; one_pass = 0; rate_value = 0;
    tbl_we = 0; tbl_waddr = 0; tbl_wdata = 0;
    for (int i = 0; i < 256; i++) begin
      tbl_m[i] = 64'hFF; rxm[i] = 8'(i); rxf[i] = 0; shf[i] = 0;
    end
    tick(3);
    chk(!tx_valid && !rx_re && !rx_clr, "R1", {tx_valid, rx_re, rx_clr}, 0);
    rst_n = 1;
    for (int i = 0; i < 256; i++) wr(i, 64'hFF);
    tick(20);
    chk(!tx_valid && !rx_re && !rx_clr && got == 0, "R1", got, 0);

    // R3 byte assembly, R9 single pass
    cur_req = "R3"; ready_mode = 1;
    rxm[8'h10] = 8'h77; rxm[8'h11] = 8'h88;
    wr(0, mk(8'h00, 8'hA5, 8'h01, 8'h10, 8'h07, 8'h3C, 8'h01, 8'h11));
    wr(1, 64'hFF);
    base = got;
    start(1);
    wait_got(base + 1, 500, "R3");
    chk(last_word == 32'h883C77A5, "R3", last_word, 32'h883C77A5);
    tick(200);
    chk(got == base + 1, "R9", got, base + 1);
    @(negedge clk); run = 0; tick(5);
    start(1);
    wait_got(base + 2, 500, "R9");
    tick(100);
    chk(got == base + 2, "R9", got, base + 2);
    stop();

    // R4/R5 conditional send and flag consumption
    cur_req = "R4";
    rxm[8'h20] = 8'h9A; set_flag(8'h20, 1);
    wr(0, mk(8'h02, 8'h20, 8'h00, 8'h11, 8'h00, 8'h22, 8'h00, 8'h33));
    wr(1, mk(8'h00, 8'h44, 8'h00, 8'h55, 8'h00, 8'h66, 8'h00, 8'h77));
    wr(2, 64'hFF);
    base = got;
    start(1);
    wait_got(base + 2, 500, "R4");
    tick(100);
    chk(rxf[8'h20] == 0, "R5", rxf[8'h20], 0);
    stop();
    base = got;
    start(1);
    wait_got(base + 1, 500, "R4");
    tick(100);
    chk(got == base + 1, "R4", got, base + 1);
    chk(last_word == 32'h77665544, "R4", last_word, 32'h77665544);
    stop();
    set_flag(8'h21, 1);
    wr(0, mk(8'h02, 8'h20, 8'h01, 8'h21, 8'h00, 8'h22, 8'h00, 8'h33));
    base = got;
    start(1);
    wait_got(base + 1, 500, "R5");
    tick(100);
    chk(rxf[8'h21] == 1, "R5", rxf[8'h21], 1);
    chk(last_word == 32'h77665544, "R5", last_word, 32'h77665544);
    stop();

    // R2 random full table with wrap, random ready
    cur_req = "R2"; ready_mode = 0;
    for (int i = 0; i < 256; i++) begin
      rxm[i] = 8'($urandom);
      set_flag(i, $urandom % 2);
    end
    for (int s = 0; s < 256; s++) begin
      bit [63:0] d;
      for (int k = 0; k < 4; k++) begin
        case ($urandom % 16)
          0, 1, 2, 3, 4, 5: op = 8'h00;
          6, 7, 8, 9, 10, 11: op = 8'h01;
          12, 13: op = 8'h07;
          default: op = 8'h02;
        endcase
        d[16*k +: 16] = {8'($urandom), op};
      end
      wr(s, d);
    end
    base = got;
    start(0);
    wait_got(base + 600, 40000, "R2");
    stop();

    // R6 end marker inside the table
    cur_req = "R6";
    wr(37, 64'h00FF);
    base = got;
    start(0);
    wait_got(base + 100, 10000, "R6");
    stop();

    // R7/R8 pass pacing
    cur_req = "R7"; ready_mode = 1;
    wr(0, mk(8'h00, 8'h01, 8'h00, 8'h02, 8'h00, 8'h03, 8'h00, 8'h04));
    wr(1, 64'hFF);
    rate_value = 16'd30;
    base = got;
    start(0);
    wait_got(base + 3, 2000, "R7");
    gap = last_hs - prev_hs;
    chk(gap >= 30 * PRE && gap <= 30 * PRE + 40, "R7", gap, 30 * PRE);
    stop();
    cur_req = "R8"; rep_now = 1;
    base = got;
    start(0);
    wait_got(base + 3, 500, "R8");
    gap = last_hs - prev_hs;
    chk(gap <= 40, "R8", gap, 40);
    stop();
    rep_now = 0; rate_value = 0;
    base = got;
    start(0);
    wait_got(base + 3, 500, "R8");
    gap = last_hs - prev_hs;
    chk(gap <= 40, "R8", gap, 40);
    stop();

    // R10/R11 stop with a word pending
    cur_req = "R10"; ready_mode = 2;
    wr(1, mk(8'h00, 8'hB1, 8'h00, 8'hB2, 8'h00, 8'hB3, 8'h00, 8'hB4));
    wr(2, 64'hFF);
    base = got;
    start(0);
    for (int t = 0; t < 200 && !tx_valid; t++) @(negedge clk);
    chk(tx_valid && tx_word == 32'h04030201, "R11", tx_word, 32'h04030201);
    @(negedge clk); run = 0;
    tick(10);
    chk(tx_valid && tx_word == 32'h04030201, "R10", tx_word, 32'h04030201);
    pulse_req = 1;
    wait_got(base + 1, 50, "R10");
    tick(50);
    chk(got == base + 1 && !tx_valid, "R10", got, base + 1);
    start(0);
    for (int t = 0; t < 200 && !tx_valid; t++) @(negedge clk);
    chk(tx_word == 32'h04030201, "R10", tx_word, 32'h04030201);
    pulse_req = 1;
    wait_got(base + 2, 50, "R10");
    @(negedge clk); run = 0;
    ready_mode = 1;
    tick(30);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule